// File: doc/BRIEF.md
# Switchless Adapter Configuration Registers

This block is the configuration register set of one expansion card that has no jumpers or switches. Each card type carries a fixed 16-bit identifier that the host reads back to learn what is plugged into a slot. The host then writes option bytes that choose the card's interrupt level, I/O window, arbitration level, burst use and memory window. The host restores these values from its own saved copy at every power-up, so the card leaves reset with every option cleared and every function idle.

Register access works only while the slot's setup-select input is high. The host raises this input for one slot at a time, so identical cards can be given settings that do not conflict. Normal bus decoding of the card is blocked for as long as setup is in progress. A sleep input lets the host idle a failed card while an identical partner card carries on. The setup registers stay readable and writable while the card sleeps.

Top module: `adapter_setup_regs`

## Requirements
- R1: After reset every option byte is 0x00. All function outputs (card_en, bus_decode_en, irq_sel, io_win, arb_level, burst_en, mem_base, aux_opt) are 0.
- R2: A read strobe while setup_sel is high returns data one clock later on rd_data, with rd_valid high for that one cycle. Offset 0 returns identifier bits 7:0 and offset 1 returns bits 15:8.
- R3: Writes to offsets 0 and 1 are ignored. The identifier reads back unchanged.
- R4: Offsets 2 to 5 are read/write option bytes. A write takes effect on the next clock edge and can be repeated at any time. A read returns the value last written.
- R5: While setup_sel is low, a write changes no register and a read gives no rd_valid.
- R6: Bit 0 of offset 2 is the enable bit. While it is 0, every function output is 0.
- R7: With the card active, the option bytes decode as follows. Offset 2 bits 3:1 drive irq_sel and bits 7:4 drive io_win. Offset 3 bits 3:0 drive arb_level and bit 4 drives burst_en. Offset 4 drives mem_base and offset 5 drives aux_opt. card_en is 1.
- R8: While sleep is high, every function output is 0. The registers keep their contents and can still be read and written. Lowering sleep restores the decoded outputs.
- R9: bus_decode_en is 1 only when the card is enabled, not asleep, and setup_sel is low.
- R10: Offsets 6 and 7 are unused. They read 0x00 and writes to them change nothing.
- R11: rd_data is 0x00 whenever rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| setup_sel | input | 1 | Selects this slot for setup; blocks normal decoding |
| reg_addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, one cycle after the strobe |
| rd_valid | output | 1 | Read data valid |
| sleep | input | 1 | Idles the card's functions |
| card_en | output | 1 | Card functions active |
| bus_decode_en | output | 1 | Normal bus decoding permitted |
| irq_sel | output | 3 | Interrupt level select |
| io_win | output | 4 | I/O window select |
| arb_level | output | 4 | Arbitration level |
| burst_en | output | 1 | Burst transfers allowed |
| mem_base | output | 8 | Memory window base |
| aux_opt | output | 8 | Auxiliary option byte |

## Verification
The decoded outputs follow the option registers combinationally. A wrong stored byte or a stray write therefore shows at the function outputs in the first cycle after the faulty clock edge, and again on the next setup readback of that offset. A read path fault shows as a wrong identifier byte or option byte one cycle after the read strobe. A gating fault shows as a non-zero output while enable is clear or sleep is high, or as bus decoding active during setup.

// File: rtl/adapter_cfg_pkg.sv
package adapter_cfg_pkg;
   localparam int BYTE_W = 8;

   typedef logic [BYTE_W-1:0] cfg_byte_t;

   typedef struct packed {
      logic [2:0] irq_sel;
      logic [3:0] io_win;
      logic [3:0] arb_level;
      logic       burst_en;
      logic [7:0] mem_base;
      logic [7:0] aux_opt;
   } res_cfg_t;

   localparam res_cfg_t RES_IDLE = '0;
endpackage

// File: rtl/adapter_id_rom.sv
module adapter_id_rom
   import adapter_cfg_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int ID_BYTES = 2,
   parameter logic [ID_BYTES*BYTE_W-1:0] CARD_ID = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output cfg_byte_t         id_byte
);
   cfg_byte_t id_arr [ID_BYTES];

   for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
      assign id_arr[g] = CARD_ID[g*BYTE_W +: BYTE_W];
   end

   always_comb begin
      hit     = 1'b0;
      id_byte = '0;
      for (int i = 0; i < ID_BYTES; i++) begin
         if (addr == ADDR_W'(i)) begin
            hit     = 1'b1;
            id_byte = id_arr[i];
         end
      end
   end
endmodule

// File: rtl/adapter_opt_regfile.sv
module adapter_opt_regfile
   import adapter_cfg_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int BASE_OFS  = 2,
   parameter int NUM_OPT   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_stb,
   input  logic [ADDR_W-1:0]         addr,
   input  cfg_byte_t                 wdata,
   output logic                      hit,
   output cfg_byte_t                 rd_byte,
   output logic [NUM_OPT*BYTE_W-1:0] opt_flat
);
   cfg_byte_t opt_q [NUM_OPT];

   for (genvar g = 0; g < NUM_OPT; g++) begin : g_byte
      localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(BASE_OFS + g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            opt_q[g] <= '0;
         else if (wr_stb && addr == MY_OFS)
            opt_q[g] <= wdata;
      end
      assign opt_flat[g*BYTE_W +: BYTE_W] = opt_q[g];
   end

   always_comb begin
      hit     = 1'b0;
      rd_byte = '0;
      for (int i = 0; i < NUM_OPT; i++) begin
         if (addr == ADDR_W'(BASE_OFS + i)) begin
            hit     = 1'b1;
            rd_byte = opt_q[i];
         end
      end
   end
endmodule

// File: rtl/adapter_res_decode.sv
module adapter_res_decode
   import adapter_cfg_pkg::*;
(
   input  cfg_byte_t ctl_byte,
   input  cfg_byte_t arb_byte,
   input  cfg_byte_t mem_byte,
   input  cfg_byte_t aux_byte,
   input  logic      sleep,
   input  logic      setup_sel,
   output logic      card_en,
   output logic      bus_decode_en,
   output res_cfg_t  res
);
   logic active;

   assign active        = ctl_byte[0] & ~sleep;
   assign card_en       = active;
   assign bus_decode_en = active & ~setup_sel;

   always_comb begin
      res = RES_IDLE;
      if (active) begin
         res.irq_sel   = ctl_byte[3:1];
         res.io_win    = ctl_byte[7:4];
         res.arb_level = arb_byte[3:0];
         res.burst_en  = arb_byte[4];
         res.mem_base  = mem_byte;
         res.aux_opt   = aux_byte;
      end
   end
endmodule

// File: rtl/adapter_setup_regs.sv
module adapter_setup_regs
   import adapter_cfg_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int ID_BYTES = 2,
   parameter int NUM_OPT  = 4,
   parameter logic [ID_BYTES*BYTE_W-1:0] CARD_ID = 16'h5A3C
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        setup_sel,
   input  logic [2:0]  reg_addr,
   input  logic        wr_en,
   input  logic [7:0]  wr_data,
   input  logic        rd_en,
   output logic [7:0]  rd_data,
   output logic        rd_valid,
   input  logic        sleep,
   output logic        card_en,
   output logic        bus_decode_en,
   output logic [2:0]  irq_sel,
   output logic [3:0]  io_win,
   output logic [3:0]  arb_level,
   output logic        burst_en,
   output logic [7:0]  mem_base,
   output logic [7:0]  aux_opt
);
   localparam int USED_OFS = ID_BYTES + NUM_OPT;

   if (ADDR_W != 3) begin : g_bad_addr
      $error("ADDR_W must match the 3-bit offset port");
   end
   if (NUM_OPT < 4) begin : g_bad_opt
      $error("NUM_OPT must be at least 4 for the decoded fields");
   end
   if (USED_OFS > (1 << ADDR_W)) begin : g_bad_map
      $error("ID and option bytes do not fit the offset space");
   end

   logic      wr_stb, rd_stb;
   logic      id_hit, opt_hit;
   cfg_byte_t id_byte, opt_byte, rd_mux;
   logic [NUM_OPT*BYTE_W-1:0] opt_flat;
   res_cfg_t  res;

   assign wr_stb = setup_sel & wr_en;
   assign rd_stb = setup_sel & rd_en;

   adapter_id_rom #(
      .ADDR_W(ADDR_W), .ID_BYTES(ID_BYTES), .CARD_ID(CARD_ID)
   ) id_rom_i (
      .addr(reg_addr), .hit(id_hit), .id_byte(id_byte)
   );

   adapter_opt_regfile #(
      .ADDR_W(ADDR_W), .BASE_OFS(ID_BYTES), .NUM_OPT(NUM_OPT)
   ) opt_rf_i (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(reg_addr),
      .wdata(wr_data), .hit(opt_hit), .rd_byte(opt_byte), .opt_flat(opt_flat)
   );

   always_comb begin
      if (id_hit)       rd_mux = id_byte;
      else if (opt_hit) rd_mux = opt_byte;
      else              rd_mux = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_stb;
         rd_data  <= rd_stb ? rd_mux : '0;
      end
   end

   adapter_res_decode dec_i (
      .ctl_byte(opt_flat[0 +: BYTE_W]),
      .arb_byte(opt_flat[BYTE_W +: BYTE_W]),
      .mem_byte(opt_flat[2*BYTE_W +: BYTE_W]),
      .aux_byte(opt_flat[3*BYTE_W +: BYTE_W]),
      .sleep(sleep), .setup_sel(setup_sel),
      .card_en(card_en), .bus_decode_en(bus_decode_en), .res(res)
   );

   assign irq_sel   = res.irq_sel;
   assign io_win    = res.io_win;
   assign arb_level = res.arb_level;
   assign burst_en  = res.burst_en;
   assign mem_base  = res.mem_base;
   assign aux_opt   = res.aux_opt;
endmodule

// File: rtl/adapter_setup_regs_chk.sv
module adapter_setup_regs_chk #(
   parameter logic [15:0] CARD_ID = 16'h5A3C
) (
   input logic       clk,
   input logic       rst_n,
   input logic       setup_sel,
   input logic [2:0] reg_addr,
   input logic       rd_en,
   input logic [7:0] rd_data,
   input logic       rd_valid,
   input logic       card_en,
   input logic       bus_decode_en,
   input logic [2:0] irq_sel,
   input logic [3:0] io_win,
   input logic [3:0] arb_level,
   input logic       burst_en,
   input logic [7:0] mem_base,
   input logic [7:0] aux_opt
);
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !card_en |-> (irq_sel == 0 && io_win == 0 && arb_level == 0 &&
                    !burst_en && mem_base == 0 && aux_opt == 0)); // R6

   AST_RD_VALID_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && setup_sel) |=> rd_valid); // R2

   AST_NO_RD_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !setup_sel) |=> !rd_valid); // R5

   AST_ID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && setup_sel && reg_addr == 3'd0) |=> rd_data == CARD_ID[7:0]); // R2

   AST_ID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && setup_sel && reg_addr == 3'd1) |=> rd_data == CARD_ID[15:8]); // R3

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && setup_sel && reg_addr >= 3'd6) |=> rd_data == 8'h00); // R10

   AST_DECODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_decode_en |-> (card_en && !setup_sel)); // R9

   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_data == 8'h00); // R11

   AST_HOLD_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!setup_sel) && card_en && $past(card_en)) |->
      ($stable(mem_base) && $stable(aux_opt) && $stable(io_win) &&
       $stable(arb_level))); // R5
endmodule

bind adapter_setup_regs adapter_setup_regs_chk #(.CARD_ID(CARD_ID)) chk_i (
   .clk(clk), .rst_n(rst_n), .setup_sel(setup_sel), .reg_addr(reg_addr),
   .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .card_en(card_en),
   .bus_decode_en(bus_decode_en), .irq_sel(irq_sel), .io_win(io_win),
   .arb_level(arb_level), .burst_en(burst_en), .mem_base(mem_base),
   .aux_opt(aux_opt)
);

// File: tb/adapter_setup_regs_tb_top.sv
`timescale 1ns/1ps
module adapter_setup_regs_tb_top;
   localparam logic [15:0] TB_ID = 16'h8E17;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       setup_sel = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic       sleep = 1'b0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       card_en, bus_decode_en, burst_en;
   logic [2:0] irq_sel;
   logic [3:0] io_win, arb_level;
   logic [7:0] mem_base, aux_opt;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   logic [7:0] exp_q [$];
   string      req_q [$];

   always #2.5 clk = ~clk;

   adapter_setup_regs #(.CARD_ID(TB_ID)) dut_i (
      .clk(clk), .rst_n(rst_n), .setup_sel(setup_sel), .reg_addr(reg_addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .rd_valid(rd_valid), .sleep(sleep), .card_en(card_en),
      .bus_decode_en(bus_decode_en), .irq_sel(irq_sel), .io_win(io_win),
      .arb_level(arb_level), .burst_en(burst_en), .mem_base(mem_base),
      .aux_opt(aux_opt)
   );

   function automatic logic [29:0] outs();
      return {card_en, bus_decode_en, irq_sel, io_win, arb_level, burst_en,
              mem_base, aux_opt};
   endfunction

   function automatic logic [29:0] ev(bit en, bit dec, logic [2:0] irq,
      logic [3:0] io, logic [3:0] arb, bit bu, logic [7:0] mb, logic [7:0] ax);
      return {en, dec, irq, io, arb, bu, mb, ax};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(bit sel, logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      setup_sel = sel; reg_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: pushes the expected byte, the monitor compares it
   task automatic bus_rd(bit sel, logic [2:0] a, logic [7:0] e, string req);
      @(negedge clk);
      setup_sel = sel; reg_addr = a; rd_en = 1'b1;
      if (sel) begin
         exp_q.push_back(e);
         req_q.push_back(req);
      end
      @(negedge clk);
      rd_en = 1'b0;
      if (!sel) begin
         chk({req, " no rd_valid"}, {31'd0, rd_valid}, 32'd0);
         chk({"R11 ", req}, {24'd0, rd_data}, 32'd0);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R5 unexpected rd_valid actual=%h expected=none", rd_data);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string r = req_q.pop_front();
            chk(r, {24'd0, rd_data}, {24'd0, e});
         end
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset outputs", {2'b0, outs()}, 32'd0);
      chk("R11 reset rd_data", {24'd0, rd_data}, 32'd0);

      // R2 identifier
      bus_rd(1, 3'd0, TB_ID[7:0], "R2 id low");
      bus_rd(1, 3'd1, TB_ID[15:8], "R2 id high");
      // R3 identifier write ignored
      bus_wr(1, 3'd0, 8'h00);
      bus_wr(1, 3'd1, 8'hFF);
      bus_rd(1, 3'd0, TB_ID[7:0], "R3 id low after write");
      bus_rd(1, 3'd1, TB_ID[15:8], "R3 id high after write");

      // R4/R6 options with enable clear
      bus_wr(1, 3'd3, 8'h1C);
      bus_wr(1, 3'd4, 8'h3F);
      bus_wr(1, 3'd5, 8'h6A);
      bus_wr(1, 3'd2, 8'hB4);
      chk("R6 disabled outputs", {2'b0, outs()}, 32'd0);
      bus_rd(1, 3'd2, 8'hB4, "R4 read ofs2");
      bus_rd(1, 3'd3, 8'h1C, "R4 read ofs3");
      bus_rd(1, 3'd4, 8'h3F, "R4 read ofs4");
      bus_rd(1, 3'd5, 8'h6A, "R4 read ofs5");

      // R7 enable and decode, during setup
      bus_wr(1, 3'd2, 8'hB5);
      chk("R7 decode in setup", {2'b0, outs()},
          {2'b0, ev(1, 0, 3'd2, 4'hB, 4'hC, 1, 8'h3F, 8'h6A)});
      @(negedge clk);
      setup_sel = 1'b0;
      #1;
      chk("R9 decode enabled", {2'b0, outs()},
          {2'b0, ev(1, 1, 3'd2, 4'hB, 4'hC, 1, 8'h3F, 8'h6A)});

      // R5 unselected access
      bus_wr(0, 3'd4, 8'h00);
      chk("R5 unselected write", {2'b0, outs()},
          {2'b0, ev(1, 1, 3'd2, 4'hB, 4'hC, 1, 8'h3F, 8'h6A)});
      bus_rd(0, 3'd4, 8'h00, "R5 unselected read");
      bus_rd(1, 3'd4, 8'h3F, "R5 ofs4 unchanged");

      // R8 sleep
      @(negedge clk);
      setup_sel = 1'b0; sleep = 1'b1;
      #1;
      chk("R8 sleep idle", {2'b0, outs()}, 32'd0);
      bus_rd(1, 3'd4, 8'h3F, "R8 read while asleep");
      bus_wr(1, 3'd5, 8'h91);
      chk("R8 still idle after write", {2'b0, outs()}, 32'd0);
      @(negedge clk);
      setup_sel = 1'b0; sleep = 1'b0;
      #1;
      chk("R8 wake restores", {2'b0, outs()},
          {2'b0, ev(1, 1, 3'd2, 4'hB, 4'hC, 1, 8'h3F, 8'h91)});

      // R4 reinit
      bus_wr(1, 3'd2, 8'h7B);
      bus_wr(1, 3'd3, 8'h05);
      chk("R4 reinit decode", {2'b0, outs()},
          {2'b0, ev(1, 0, 3'd5, 4'h7, 4'h5, 0, 8'h3F, 8'h91)});

      // R10 unused offsets
      bus_wr(1, 3'd6, 8'hFF);
      bus_wr(1, 3'd7, 8'hEE);
      bus_rd(1, 3'd6, 8'h00, "R10 ofs6");
      bus_rd(1, 3'd7, 8'h00, "R10 ofs7");
      chk("R10 outputs unchanged", {2'b0, outs()},
          {2'b0, ev(1, 0, 3'd5, 4'h7, 4'h5, 0, 8'h3F, 8'h91)});

      // R6 clear enable
      bus_wr(1, 3'd2, 8'h7A);
      @(negedge clk);
      setup_sel = 1'b0;
      #1;
      chk("R6 enable cleared", {2'b0, outs()}, 32'd0);
      bus_rd(1, 3'd2, 8'h7A, "R6 ofs2 readback");

      repeat (3) @(negedge clk);
      chk("R2 scoreboard drained", exp_q.size(), 32'd0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule